// File: doc/BRIEF.md
# Retimed Ripple Clock Divider

This block turns a fast oscillator clock into a feedback clock at one quarter of its rate, for use by a phase comparator that runs at the reference rate. It divides with a chain of toggle flip-flops. Each toggle flip-flop loads its own inverse, and each one after the first is clocked by the output of the one before it. This is the cheap, fast way to divide. Its drawback is that every link in the chain adds its own clock-to-output delay and spread to the final edge.

To remove that accumulated error, a last flip-flop samples the end of the chain on the fast clock itself. Every edge of the divided clock then sits on a rising edge of the fast clock, one fast cycle behind the chain's own edge. The block brings out three signals: the first-stage tap at half rate, the raw end of the chain, and the retimed output.

The chain length is a parameter, so the division ratio is a power of two. The default length of two gives a ratio of four. Every stage is a two-state machine with the states LVL_LOW and LVL_HIGH:
- A toggle stage takes the transition TOGGLE_UP (LVL_LOW to LVL_HIGH) or TOGGLE_DOWN (LVL_HIGH to LVL_LOW) on every rising edge of its clock.
- The retiming stage takes the transition RETIME_RISE (LVL_LOW to LVL_HIGH) when it samples the chain high.
- The retiming stage takes the transition RETIME_FALL (LVL_HIGH to LVL_LOW) when it samples the chain low.
- Otherwise the retiming stage holds its state.

Top module: `rdiv_retimed_div4`

## Requirements
- R1: While rst_n is low, tap_div2, ripple_out and retimed_out are all 0.
- R2: After reset is released, tap_div2 changes value on every rising edge of clk_fast. Its first rise comes on the first rising edge after release.
- R3: Each chain stage after the first changes value exactly when the stage before it rises. ripple_out is the last stage, so it first rises on the first fast edge after release. Its period is 2^NUM_STAGES fast cycles.
- R4: retimed_out at each rising edge of clk_fast takes the value ripple_out had just before that edge. This is a latency of exactly one fast cycle. Before the first edge after release, retimed_out is 0.
- R5: retimed_out changes only at rising edges of clk_fast. It holds steady at all times between rising edges.
- R6: With the default NUM_STAGES = 2, retimed_out has a period of exactly four fast cycles. It is high for two fast cycles and low for two, and its first rise comes on the second fast edge after release.
- R7: Pulling rst_n low at any time clears all three outputs at once, without waiting for a clock edge. After release, the sequence restarts from its first edge as in R2 to R4.
- R8: NUM_STAGES (at least 1) sets the division ratio to 2^NUM_STAGES. With NUM_STAGES = 3, retimed_out has a period of eight fast cycles, four high and four low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast oscillator clock; clocks the first toggle stage and the retiming stage |
| rst_n | input | 1 | Active-low asynchronous reset for every stage |
| tap_div2 | output | 1 | First toggle stage output, fast clock divided by two |
| ripple_out | output | 1 | Last toggle stage output, raw ripple-divided clock |
| retimed_out | output | 1 | Ripple output re-sampled on clk_fast |

## Verification
The bench builds the block twice side by side on the same clock and reset. One copy uses the default NUM_STAGES = 2, the ratio-four case that is the block's main use. The other copy uses NUM_STAGES = 3. Its three-deep chain has a middle stage that is clocked by another ripple stage rather than by the fast clock, so it exercises the cascade rule of R3 beyond the first link. It also shows that the half-high, half-low shape of the retimed output scales with the ratio. Both copies are compared edge by edge against a count-based model after a clean start and after a reset pulled mid-run.

// File: rtl/rdiv_pkg.sv
`timescale 1ns/1ps
package rdiv_pkg;

    // Level held by a single divider stage
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    // Opposite level, used by the toggle stages
    function automatic lvl_e lvl_flip(input lvl_e cur);
        lvl_e res;
        unique case (cur)
            LVL_LOW:  res = LVL_HIGH;
            LVL_HIGH: res = LVL_LOW;
            default:  res = LVL_LOW;
        endcase
        return res;
    endfunction

    // Level taken from a sampled single-bit signal
    function automatic lvl_e lvl_from_bit(input logic b);
        return b ? LVL_HIGH : LVL_LOW;
    endfunction

endpackage

// File: rtl/rdiv_toggle_stage.sv
`timescale 1ns/1ps
// One divide-by-two link: the stage loads its own inverse on every rising
// edge of its local clock.
module rdiv_toggle_stage
    import rdiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    output logic q_o
);

    lvl_e state_q;
    lvl_e state_d;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: TOGGLE_UP and TOGGLE_DOWN
    always_comb begin
        unique case (state_q)
            LVL_LOW:  state_d = lvl_flip(LVL_LOW);
            LVL_HIGH: state_d = lvl_flip(LVL_HIGH);
            default:  state_d = LVL_LOW;
        endcase
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            LVL_LOW:  q_o = 1'b0;
            LVL_HIGH: q_o = 1'b1;
            default:  q_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rdiv_retime_stage.sv
`timescale 1ns/1ps
// Synchronous re-sampler: copies the ripple chain's end onto the fast clock
// so that every output edge is aligned to a fast rising edge.
module rdiv_retime_stage
    import rdiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    lvl_e state_q;
    lvl_e state_d;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: RETIME_RISE, RETIME_FALL, or hold
    always_comb begin
        unique case (state_q)
            LVL_LOW:  state_d = d_i ? LVL_HIGH : LVL_LOW;
            LVL_HIGH: state_d = d_i ? LVL_HIGH : LVL_LOW;
            default:  state_d = lvl_from_bit(d_i);
        endcase
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            LVL_LOW:  q_o = 1'b0;
            LVL_HIGH: q_o = 1'b1;
            default:  q_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rdiv_retimed_div4.sv
`timescale 1ns/1ps
// Ripple divider by 2^NUM_STAGES with a synchronous retiming stage.
module rdiv_retimed_div4 #(
    parameter int NUM_STAGES = 2
) (
    input  logic clk_fast,
    input  logic rst_n,
    output logic tap_div2,
    output logic ripple_out,
    output logic retimed_out
);

    localparam int LAST = NUM_STAGES - 1;

    logic [NUM_STAGES-1:0] stage_q;

    // Ripple chain: stage 0 on the fast clock, each later stage clocked by
    // the stage before it.
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_chain
        if (g == 0) begin : g_head
            rdiv_toggle_stage u_tog (
                .clk_i  (clk_fast),
                .rst_ni (rst_n),
                .q_o    (stage_q[g])
            );
        end else begin : g_link
            rdiv_toggle_stage u_tog (
                .clk_i  (stage_q[g-1]),
                .rst_ni (rst_n),
                .q_o    (stage_q[g])
            );
        end
    end

    rdiv_retime_stage u_retime (
        .clk_i  (clk_fast),
        .rst_ni (rst_n),
        .d_i    (stage_q[LAST]),
        .q_o    (retimed_out)
    );

    assign tap_div2   = stage_q[0];
    assign ripple_out = stage_q[LAST];

endmodule

// File: rtl/rdiv_checker.sv
`timescale 1ns/1ps
module rdiv_checker #(
    parameter int NUM_STAGES = 2
) (
    input logic                  clk_fast,
    input logic                  rst_n,
    input logic                  tap_div2,
    input logic                  ripple_out,
    input logic                  retimed_out,
    input logic [NUM_STAGES-1:0] stage_q
);

    AST_RESET_CLEARS: assert property (@(posedge clk_fast)
        !rst_n |-> (!tap_div2 && !ripple_out && !retimed_out)); // R1

    AST_TAP_TOGGLES: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $past(rst_n) |-> (tap_div2 != $past(tap_div2))); // R2

    AST_RETIME_LATENCY: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $past(rst_n) |-> (retimed_out == $past(ripple_out))); // R4

    for (genvar g = 1; g < NUM_STAGES; g++) begin : g_links
        AST_STAGE_ON_RISE: assert property (@(posedge clk_fast) disable iff (!rst_n)
            ($past(rst_n) && (stage_q[g] != $past(stage_q[g])))
                |-> (stage_q[g-1] && !$past(stage_q[g-1]))); // R3
    end

    if (NUM_STAGES > 1) begin : g_duty
        AST_NO_SHORT_PHASE: assert property (@(posedge clk_fast) disable iff (!rst_n)
            ($past(rst_n) && (retimed_out != $past(retimed_out)))
                |=> $stable(retimed_out)); // R6
    end

endmodule

bind rdiv_retimed_div4 rdiv_checker #(.NUM_STAGES(NUM_STAGES)) u_chk (.*);

// File: tb/rdiv_retimed_div4_test.sv
`timescale 1ns/1ps
module rdiv_retimed_div4_test;

    logic clk_fast = 1'b0;
    logic rst_n    = 1'b0;
    logic tap2_a, rip_a, ret_a;
    logic tap2_b, rip_b, ret_b;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk_fast = ~clk_fast;   // 250 MHz

    rdiv_retimed_div4 #(.NUM_STAGES(2)) uut (
        .clk_fast(clk_fast), .rst_n(rst_n),
        .tap_div2(tap2_a), .ripple_out(rip_a), .retimed_out(ret_a)
    );

    rdiv_retimed_div4 #(.NUM_STAGES(3)) uut3 (
        .clk_fast(clk_fast), .rst_n(rst_n),
        .tap_div2(tap2_b), .ripple_out(rip_b), .retimed_out(ret_b)
    );

    // Model: value of chain stage idx after e fast edges since release
    function automatic int exp_stage(int e, int idx);
        int r = e;
        for (int k = 0; k < idx; k++) r = (r + 1) >> 1;
        return r & 1;
    endfunction

    function automatic int exp_ret(int e, int nst);
        if (e == 0) return 0;
        return exp_stage(e - 1, nst - 1);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic release_reset();
        @(negedge clk_fast);
        rst_n = 1'b1;
    endtask

    // R1: all outputs low while reset is held
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk_fast);
        check(tap2_a == 0, "R1", "tap_div2", int'(tap2_a), 0);
        check(rip_a  == 0, "R1", "ripple_out", int'(rip_a), 0);
        check(ret_a  == 0, "R1", "retimed_out", int'(ret_a), 0);
        check(tap2_b == 0, "R1", "tap_div2 n3", int'(tap2_b), 0);
        check(rip_b  == 0, "R1", "ripple_out n3", int'(rip_b), 0);
        check(ret_b  == 0, "R1", "retimed_out n3", int'(ret_b), 0);
    endtask

    // R2 R3 R4 R5: edge-by-edge comparison against the count model
    task automatic t_sequence(int n);
        release_reset();
        for (int e = 1; e <= n; e++) begin
            logic early_a, early_b;
            @(posedge clk_fast);
            #1;
            early_a = ret_a;
            early_b = ret_b;
            @(negedge clk_fast);
            check(int'(tap2_a) == exp_stage(e, 0), "R2", "tap_div2", int'(tap2_a), exp_stage(e, 0));
            check(int'(tap2_b) == exp_stage(e, 0), "R2", "tap_div2 n3", int'(tap2_b), exp_stage(e, 0));
            check(int'(rip_a) == exp_stage(e, 1), "R3", "ripple_out", int'(rip_a), exp_stage(e, 1));
            check(int'(rip_b) == exp_stage(e, 2), "R3", "ripple_out n3", int'(rip_b), exp_stage(e, 2));
            check(int'(ret_a) == exp_ret(e, 2), "R4", "retimed_out", int'(ret_a), exp_ret(e, 2));
            check(int'(ret_b) == exp_ret(e, 3), "R4", "retimed_out n3", int'(ret_b), exp_ret(e, 3));
            check(early_a == ret_a, "R5", "retimed_out moved mid-cycle", int'(ret_a), int'(early_a));
            check(early_b == ret_b, "R5", "retimed_out n3 moved mid-cycle", int'(ret_b), int'(early_b));
        end
    endtask

    // R6 R8: period and high time of the retimed output
    task automatic t_period();
        int last_rise_a = -1, last_rise_b = -1;
        int last_fall_a = -1, last_fall_b = -1;
        logic prev_a = 1'b0, prev_b = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk_fast);
        release_reset();
        for (int e = 1; e <= 48; e++) begin
            @(negedge clk_fast);
            if (ret_a && !prev_a) begin
                if (last_rise_a < 0)
                    check(e == 2, "R6", "first rise edge", e, 2);
                else
                    check(e - last_rise_a == 4, "R6", "period", e - last_rise_a, 4);
                last_rise_a = e;
            end
            if (!ret_a && prev_a) begin
                check(e - last_rise_a == 2, "R6", "high time", e - last_rise_a, 2);
                last_fall_a = e;
            end
            if (ret_b && !prev_b) begin
                if (last_rise_b >= 0)
                    check(e - last_rise_b == 8, "R8", "period n3", e - last_rise_b, 8);
                last_rise_b = e;
            end
            if (!ret_b && prev_b) begin
                check(e - last_rise_b == 4, "R8", "high time n3", e - last_rise_b, 4);
                last_fall_b = e;
            end
            prev_a = ret_a;
            prev_b = ret_b;
        end
        check(last_fall_a > 40, "R6", "last fall seen", last_fall_a, 41);
        check(last_fall_b > 36, "R8", "last fall seen n3", last_fall_b, 37);
    endtask

    // R7: asynchronous clear mid-run, then a clean restart
    task automatic t_midreset();
        repeat (7) @(negedge clk_fast);
        #0.5;
        rst_n = 1'b0;
        #0.5;
        check({tap2_a, rip_a, ret_a} == 3'b000, "R7", "clear n2", int'({tap2_a, rip_a, ret_a}), 0);
        check({tap2_b, rip_b, ret_b} == 3'b000, "R7", "clear n3", int'({tap2_b, rip_b, ret_b}), 0);
        repeat (2) @(negedge clk_fast);
        check({tap2_a, ret_a, tap2_b, ret_b} == 4'b0000, "R7", "held clear",
              int'({tap2_a, ret_a, tap2_b, ret_b}), 0);
        t_sequence(12);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_sequence(20);
        t_period();
        t_midreset();
        report();
    end

    initial begin
        repeat (200000) @(posedge clk_fast);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            report();
        end
    end

endmodule